// File: doc/BRIEF.md
# Root Port Error Collector

This block holds the root-level error status, error source and root command state of a root port. Each incoming error message carries a severity code and a 16-bit requester ID. The block records which classes of error have arrived and whether one class arrived more than once. It records whether the first uncorrectable error was fatal. It captures the requester ID of the first correctable error and of the first uncorrectable error.

Software clears event flags through a write-one-to-clear mask and programs a three-bit enable word. A device-specific path loads the interrupt message number into the top five bits of the status word.

While message interrupts are off, the block drives a level interrupt. While they are on, it emits a single-cycle message request with the stored vector, and only when the condition "some enabled class is pending" goes from false to true.

Top module: `root_err_collector`

## Requirements
- R1: After reset the command word, the status word, both source registers, `irq_o` and `msi_req_o` are all zero.
- R2: A correctable message (severity code 0) sets status bit 0. If bit 0 was already set, it also sets bit 1 and leaves `cor_src_o` unchanged. Otherwise it loads `cor_src_o` with the requester ID.
- R3: A non-fatal message (severity code 1) sets status bit 5 and status bit 2. It never sets bit 4.
- R4: A fatal message (severity code 2) sets status bit 6 and status bit 2. It also sets bit 4 when bit 2 was clear before the message.
- R5: A non-fatal or fatal message that arrives while bit 2 is already set also sets bit 3 and leaves `uncor_src_o` unchanged. If bit 2 was clear, it loads `uncor_src_o` with the requester ID.
- R6: A pulse on `sts_clr_we_i` clears each of status bits 6..0 whose mask bit is 1. A flag that a message sets in the same cycle stays set. Bits 26..7 always read zero.
- R7: `vec_we_i` loads `vec_i` into status bits 31..27. Write-one-to-clear leaves these bits untouched.
- R8: While `msi_en_i` is 0, `irq_o` is 1 exactly when some enable bit is 1 and its class is pending. Command bit 0 pairs with status bit 0, bit 1 with bit 5, and bit 2 with bit 6. While `msi_en_i` is 1, `irq_o` is 0.
- R9: While `msi_en_i` is 1, a message asserts `msi_req_o` for one cycle, with `msi_vec_o` equal to status bits 31..27, in the cycle its status update appears. This happens only if the command enables that message's class and no enabled class was pending before the message.
- R10: A command write asserts `msi_req_o` for one cycle only if the enabled-and-pending condition was false under the old command and is true under the new one.
- R11: A message with severity code 3 changes no status or source register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Error message strobe |
| msg_sev_i | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal, 3 none |
| msg_rid_i | input | 16 | Requester ID of the message |
| cmd_we_i | input | 1 | Root command write strobe |
| cmd_wdata_i | input | 3 | Enables: bit0 correctable, bit1 non-fatal, bit2 fatal |
| sts_clr_we_i | input | 1 | Write-one-to-clear strobe for event flags |
| sts_clr_i | input | 7 | Clear mask for status bits 6..0 |
| vec_we_i | input | 1 | Message number load strobe |
| vec_i | input | 5 | Message number value |
| msi_en_i | input | 1 | Message interrupts enabled |
| cmd_o | output | 3 | Root command word |
| sts_o | output | 32 | Root status word |
| cor_src_o | output | 16 | Correctable source ID |
| uncor_src_o | output | 16 | Uncorrectable source ID |
| irq_o | output | 1 | Level interrupt |
| msi_req_o | output | 1 | One-cycle message interrupt request |
| msi_vec_o | output | 5 | Vector sent with the request |

## Verification
Some rules are checked by assertions on every cycle:
- a multiple flag only rises while its received flag was set;
- the first-fatal flag only rises together with fatal-received on an empty uncorrectable record;
- a source register holds while its received flag stays set;
- the message number moves only on its load strobe;
- a message request never lasts two cycles and is only raised while an enabled class is pending.

Other behaviours can only be shown by the bench's directed sequences:
- the exact status values after mixed severities;
- the clear-versus-message race;
- the level interrupt under each enable pattern;
- which command writes and messages produce a request and which are suppressed because the condition was already true.

// File: rtl/root_err_pkg.sv
package root_err_pkg;
  typedef enum logic [1:0] {
    SEV_COR   = 2'd0,
    SEV_NFAT  = 2'd1,
    SEV_FAT   = 2'd2,
    SEV_NONE  = 2'd3
  } sev_e;

  localparam int NFLAG  = 7;
  localparam int F_COR  = 0;
  localparam int F_MCOR = 1;
  localparam int F_UNC  = 2;
  localparam int F_MUNC = 3;
  localparam int F_FFAT = 4;
  localparam int F_NFAT = 5;
  localparam int F_FAT  = 6;

  localparam int NCLS   = 3;

  // pending class vector aligned with command enables
  function automatic logic [NCLS-1:0] flags_to_cls(input logic [NFLAG-1:0] f);
    return {f[F_FAT], f[F_NFAT], f[F_COR]};
  endfunction
endpackage

// File: rtl/root_err_status.sv
module root_err_status
  import root_err_pkg::*;
#(
  parameter int RID_W = 16,
  parameter int VEC_W = 5,
  parameter int STS_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             msg_valid_i,
  input  sev_e             msg_sev_i,
  input  logic [RID_W-1:0] msg_rid_i,
  input  logic             clr_we_i,
  input  logic [NFLAG-1:0] clr_mask_i,
  input  logic             vec_we_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic [STS_W-1:0] sts_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [NCLS-1:0]  pend_o,
  output logic [NCLS-1:0]  pend_nxt_o,
  output logic [RID_W-1:0] cor_src_o,
  output logic [RID_W-1:0] uncor_src_o
);
  localparam int VEC_LSB = STS_W - VEC_W;

  logic [NFLAG-1:0] flags_q, flags_d, set_v, clr_v;
  logic [VEC_W-1:0] vec_q;
  logic [RID_W-1:0] cor_src_q, unc_src_q;
  logic             is_cor, is_unc;

  assign is_cor = msg_valid_i && (msg_sev_i == SEV_COR);
  assign is_unc = msg_valid_i && (msg_sev_i == SEV_NFAT || msg_sev_i == SEV_FAT);

  always_comb begin
    set_v = '0;
    if (is_cor) begin
      set_v[F_COR] = 1'b1;
      if (flags_q[F_COR]) set_v[F_MCOR] = 1'b1;
    end
    if (is_unc) begin
      set_v[F_UNC] = 1'b1;
      if (flags_q[F_UNC]) set_v[F_MUNC] = 1'b1;
      if (msg_sev_i == SEV_FAT) begin
        set_v[F_FAT] = 1'b1;
        if (!flags_q[F_UNC]) set_v[F_FFAT] = 1'b1;
      end else begin
        set_v[F_NFAT] = 1'b1;
      end
    end
  end

  assign clr_v   = clr_we_i ? clr_mask_i : '0;
  // message sets win over a same-cycle clear
  assign flags_d = (flags_q & ~clr_v) | set_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q   <= '0;
      vec_q     <= '0;
      cor_src_q <= '0;
      unc_src_q <= '0;
    end else begin
      flags_q <= flags_d;
      if (vec_we_i) vec_q <= vec_i;
      if (is_cor && !flags_q[F_COR]) cor_src_q <= msg_rid_i;
      if (is_unc && !flags_q[F_UNC]) unc_src_q <= msg_rid_i;
    end
  end

  always_comb begin
    sts_o = '0;
    sts_o[NFLAG-1:0] = flags_q;
    sts_o[VEC_LSB +: VEC_W] = vec_q;
  end

  assign vec_o       = vec_q;
  assign pend_o      = flags_to_cls(flags_q);
  assign pend_nxt_o  = flags_to_cls(flags_d);
  assign cor_src_o   = cor_src_q;
  assign uncor_src_o = unc_src_q;

  p_multi_cor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_q[F_MCOR]) |-> $past(flags_q[F_COR]));
  p_cor_src_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[F_COR] && $past(flags_q[F_COR])) |-> $stable(cor_src_q));
  p_first_fatal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_q[F_FFAT]) |-> (!$past(flags_q[F_UNC]) && flags_q[F_FAT]));
  p_multi_unc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_q[F_MUNC]) |-> $past(flags_q[F_UNC]));
  p_unc_src_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[F_UNC] && $past(flags_q[F_UNC])) |-> $stable(unc_src_q));
  p_vec_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_we_i |=> $stable(vec_q));
endmodule

// File: rtl/root_err_irq.sv
module root_err_irq
  import root_err_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [NCLS-1:0]  cmd_wdata_i,
  input  logic             msi_en_i,
  input  logic [NCLS-1:0]  pend_i,
  input  logic [NCLS-1:0]  pend_nxt_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic [NCLS-1:0]  cmd_o,
  output logic             irq_o,
  output logic             msi_req_o,
  output logic [VEC_W-1:0] msi_vec_o
);
  logic [NCLS-1:0]  cmd_q, cmd_d;
  logic             cond_cur, cond_nxt, fire;
  logic             msi_q;
  logic [VEC_W-1:0] msi_vec_q;

  assign cmd_d    = cmd_we_i ? cmd_wdata_i : cmd_q;
  assign cond_cur = |(cmd_q & pend_i);
  assign cond_nxt = |(cmd_d & pend_nxt_i);
  // one edge detector covers both message arrival and command writes
  assign fire     = msi_en_i && !cond_cur && cond_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      msi_q     <= 1'b0;
      msi_vec_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      msi_q <= fire;
      if (fire) msi_vec_q <= vec_i;
    end
  end

  assign cmd_o     = cmd_q;
  assign irq_o     = !msi_en_i && cond_cur;
  assign msi_req_o = msi_q;
  assign msi_vec_o = msi_vec_q;

  p_msi_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_q |=> !msi_q);
  p_msi_cond_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_q |-> |(cmd_q & pend_i));
  p_cmd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_we_i |=> $stable(cmd_q));
endmodule

// File: rtl/root_err_collector.sv
module root_err_collector
  import root_err_pkg::*;
#(
  parameter int RID_W = 16,
  parameter int VEC_W = 5,
  parameter int STS_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             msg_valid_i,
  input  logic [1:0]       msg_sev_i,
  input  logic [RID_W-1:0] msg_rid_i,
  input  logic             cmd_we_i,
  input  logic [2:0]       cmd_wdata_i,
  input  logic             sts_clr_we_i,
  input  logic [6:0]       sts_clr_i,
  input  logic             vec_we_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             msi_en_i,
  output logic [2:0]       cmd_o,
  output logic [STS_W-1:0] sts_o,
  output logic [RID_W-1:0] cor_src_o,
  output logic [RID_W-1:0] uncor_src_o,
  output logic             irq_o,
  output logic             msi_req_o,
  output logic [VEC_W-1:0] msi_vec_o
);
  logic [NCLS-1:0]  pend, pend_nxt;
  logic [VEC_W-1:0] vec;

  root_err_status #(.RID_W(RID_W), .VEC_W(VEC_W), .STS_W(STS_W)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .msg_valid_i (msg_valid_i),
    .msg_sev_i   (sev_e'(msg_sev_i)),
    .msg_rid_i   (msg_rid_i),
    .clr_we_i    (sts_clr_we_i),
    .clr_mask_i  (sts_clr_i),
    .vec_we_i    (vec_we_i),
    .vec_i       (vec_i),
    .sts_o       (sts_o),
    .vec_o       (vec),
    .pend_o      (pend),
    .pend_nxt_o  (pend_nxt),
    .cor_src_o   (cor_src_o),
    .uncor_src_o (uncor_src_o)
  );

  root_err_irq #(.VEC_W(VEC_W)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_we_i    (cmd_we_i),
    .cmd_wdata_i (cmd_wdata_i),
    .msi_en_i    (msi_en_i),
    .pend_i      (pend),
    .pend_nxt_i  (pend_nxt),
    .vec_i       (vec),
    .cmd_o       (cmd_o),
    .irq_o       (irq_o),
    .msi_req_o   (msi_req_o),
    .msi_vec_o   (msi_vec_o)
  );
endmodule

// File: tb/tb_root_err_collector.sv
module tb_root_err_collector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic [1:0]  msg_sev = 2'd0;
  logic [15:0] msg_rid = '0;
  logic        cmd_we = 1'b0;
  logic [2:0]  cmd_wdata = '0;
  logic        clr_we = 1'b0;
  logic [6:0]  clr_mask = '0;
  logic        vec_we = 1'b0;
  logic [4:0]  vec_in = '0;
  logic        msi_en = 1'b0;
  logic [2:0]  cmd;
  logic [31:0] sts;
  logic [15:0] cor_src, unc_src;
  logic        irq, msi_req;
  logic [4:0]  msi_vec;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] vbits = '0;

  always #4 clk = ~clk;

  root_err_collector dut (
    .clk_i(clk), .rst_ni(rst_n),
    .msg_valid_i(msg_valid), .msg_sev_i(msg_sev), .msg_rid_i(msg_rid),
    .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata),
    .sts_clr_we_i(clr_we), .sts_clr_i(clr_mask),
    .vec_we_i(vec_we), .vec_i(vec_in), .msi_en_i(msi_en),
    .cmd_o(cmd), .sts_o(sts), .cor_src_o(cor_src), .uncor_src_o(unc_src),
    .irq_o(irq), .msi_req_o(msi_req), .msi_vec_o(msi_vec)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send(logic [1:0] sev, logic [15:0] rid);
    msg_valid = 1'b1; msg_sev = sev; msg_rid = rid;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic wr_cmd(logic [2:0] v);
    cmd_we = 1'b1; cmd_wdata = v;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic clr(logic [6:0] m);
    clr_we = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 cmd", 32'(cmd), 0);
    chk("R1 sts", sts, 0);
    chk("R1 srcs", {cor_src, unc_src}, 0);
    chk("R1 irq/msi", {30'd0, irq, msi_req}, 0);
  endtask

  task automatic t_vector;
    vec_we = 1'b1; vec_in = 5'h15;
    @(negedge clk);
    vec_we = 1'b0;
    vbits = 32'hA800_0000;
    chk("R7 vector load", sts, vbits);
    clr(7'h7F);
    chk("R7 vector survives clear", sts, vbits);
  endtask

  task automatic t_cor;
    send(2'd0, 16'h1234);
    chk("R2 first cor sts", sts, vbits | 32'h1);
    chk("R2 first cor src", 32'(cor_src), 32'h1234);
    send(2'd0, 16'h5678);
    chk("R2 second cor sts", sts, vbits | 32'h3);
    chk("R2 src held", 32'(cor_src), 32'h1234);
    clr(7'h7F);
    chk("R6 clear all", sts, vbits);
  endtask

  task automatic t_uncor;
    send(2'd1, 16'hAAAA);
    chk("R3 nonfatal sts", sts, vbits | 32'h24);
    chk("R5 first unc src", 32'(unc_src), 32'hAAAA);
    send(2'd2, 16'hBBBB);
    chk("R5 multi unc, R4 no first-fatal", sts, vbits | 32'h6C);
    chk("R5 unc src held", 32'(unc_src), 32'hAAAA);
    clr(7'h7F);
  endtask

  task automatic t_fatal_first;
    send(2'd2, 16'hCCCC);
    chk("R4 first fatal sts", sts, vbits | 32'h54);
    chk("R4 unc src", 32'(unc_src), 32'hCCCC);
    clr(7'h10);
    chk("R6 partial clear", sts, vbits | 32'h44);
    clr(7'h7F);
  endtask

  task automatic t_ignore;
    send(2'd3, 16'hDEAD);
    chk("R11 sts untouched", sts, vbits);
    chk("R11 srcs untouched", {cor_src, unc_src}, 32'h1234_CCCC);
  endtask

  task automatic t_clear_race;
    send(2'd0, 16'h0101);
    clr_we = 1'b1; clr_mask = 7'h01;
    send(2'd0, 16'h0202);
    clr_we = 1'b0;
    chk("R6 message wins clear", sts, vbits | 32'h3);
    chk("R6 src from first", 32'(cor_src), 32'h0101);
    clr(7'h7F);
  endtask

  task automatic t_level;
    msi_en = 1'b0;
    wr_cmd(3'b001);
    chk("R8 no pend", 32'(irq), 0);
    send(2'd0, 16'h1);
    chk("R8 cor enabled", 32'(irq), 1);
    wr_cmd(3'b110);
    chk("R8 cor disabled", 32'(irq), 0);
    send(2'd2, 16'h2);
    chk("R8 fatal enabled", 32'(irq), 1);
    chk("R8 no msi when disabled", 32'(msi_req), 0);
    msi_en = 1'b1;
    #1;
    chk("R8 level off with msi", 32'(irq), 0);
  endtask

  task automatic t_msg_irq;
    clr(7'h7F);
    wr_cmd(3'b001);
    chk("R10 no pend no msi", 32'(msi_req), 0);
    send(2'd0, 16'h3);
    chk("R9 msi pulse", 32'(msi_req), 1);
    chk("R9 msi vec", 32'(msi_vec), 32'h15);
    @(negedge clk);
    chk("R9 single cycle", 32'(msi_req), 0);
    send(2'd0, 16'h4);
    chk("R9 already pending", 32'(msi_req), 0);
    send(2'd1, 16'h5);
    chk("R9 class not enabled", 32'(msi_req), 0);
  endtask

  task automatic t_cmd_irq;
    wr_cmd(3'b011);
    chk("R10 cond already true", 32'(msi_req), 0);
    clr(7'h7F);
    wr_cmd(3'b000);
    send(2'd1, 16'h6);
    chk("R10 pend but disabled", 32'(msi_req), 0);
    wr_cmd(3'b010);
    chk("R10 enable rises cond", 32'(msi_req), 1);
    chk("R10 cmd readback", 32'(cmd), 32'h2);
    @(negedge clk);
    chk("R10 single cycle", 32'(msi_req), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_vector();
    t_cor();
    t_uncor();
    t_fatal_first();
    t_ignore();
    t_clear_race();
    t_level();
    t_msg_irq();
    t_cmd_irq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule